// File: doc/BRIEF.md
# Two-Operand Operand Sequencer

This block sits between instruction decode and the ALU of a 16-bit CPU with sixteen registers and one shared memory for code and data. It accepts a two-operand instruction word, works out where the source operand comes from, and fetches it. The source can be a register, a memory word, or a hard-wired constant. It reads the extension words that follow the instruction and computes effective addresses. It performs auto-increment register updates. It then reports the source value, together with the kind and location of the destination. Each extension word is read at the program counter, and the program counter then advances by 2. The source extension word always comes before the destination extension word.

Register R0 is the program counter and R1 is the stack pointer. Register R2 holds the status word, but in some source modes it gives a zero base (absolute addressing) or the constants 4 and 8. Register R3 never touches memory: as a source it produces a constant, and as a destination it makes the result be discarded.

Instructions enter on a valid/ready pair. The caller keeps `instr_valid` and `instr_word` steady until `instr_ready` is seen high at a clock edge. `instr_ready` is high only while the block is idle, so a new word is refused until the previous one has finished. Memory reads use a request/valid pair. While `mem_req` is high the address holds, and the block waits in that state until `mem_rvalid` comes back. `mem_rvalid` may arrive in the same cycle as the request.

Top module: `opnd_seq`

## Requirements
- R1: The instruction word is split into opcode [15:12], source register [11:8], destination mode [7], byte flag [6], source mode [5:4] and destination register [3:0]. A word is taken when `instr_valid` and `instr_ready` are both high at a clock edge. `instr_ready` is high exactly when the block is idle, and after reset it is high with `mem_req` and `done` low.
- R2: Source mode 00 delivers the current contents of the named register. For R2 this is the status word.
- R3: R3 as a source delivers 0, 1, 2 or 0xFFFF for modes 00, 01, 10 and 11. R2 in mode 10 delivers 4 and in mode 11 delivers 8. None of these reads memory or writes a register, and when no destination extension is needed `done` rises in the cycle after acceptance.
- R4: Source mode 01 reads an index word at the PC and advances the PC by 2. The operand is then read at base+index. The base is the register value, except that it is 0 for R2 and the index word's own address for R0.
- R5: Source mode 10 reads the operand at the address held in the register and leaves that register unchanged.
- R6: Source mode 11 reads at the register's address and then adds 2 to the register, or 1 for byte operations. R0 and R1 always step by 2, so mode 11 on R0 yields the immediate word after the instruction.
- R7: Destination mode 0 reports kind register (`dst_kind`=0) with `dst_loc` holding the register number. Mode 1 reads an index word at the PC, advances the PC by 2 and reports kind memory (`dst_kind`=1) with `dst_loc` = base+index, using the R4 base rules. R3 as a destination reports kind discard (`dst_kind`=2), `dst_loc`=0, and reads no index word, while any source auto-increment still happens.
- R8: When both fields need extension words, the source word is read first and the destination word at the next PC. The destination base is read after any source auto-increment has been written.
- R9: Each memory state takes one cycle plus the wait for `mem_rvalid`. While a request is unanswered, `mem_req` stays high and `mem_addr` does not change.
- R10: `done` is high for exactly one cycle. `src_val`, `dst_kind`, `dst_loc`, `op_out` and `byte_out` are valid from then on until the next word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Block idle, word will be taken |
| instr_word | input | 16 | Two-operand instruction word |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | DW | Byte address of the read |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | DW | Read data word |
| rf_rs_addr | output | 4 | Register file read port A index (source) |
| rf_rs_data | input | DW | Register file read port A data |
| rf_rd_addr | output | 4 | Register file read port B index (PC when idle, else destination) |
| rf_rd_data | input | DW | Register file read port B data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 4 | Register write index |
| rf_wdata | output | DW | Register write data |
| done | output | 1 | One-cycle completion pulse |
| src_val | output | DW | Source operand value |
| dst_kind | output | 2 | 0 register, 1 memory, 2 discard |
| dst_loc | output | DW | Destination register number or address |
| op_out | output | 4 | Opcode field of the accepted word |
| byte_out | output | 1 | Byte flag of the accepted word |

## Verification
Two events can land in the same clock edge: a memory read completes, and the register auto-increment is written back. With zero-latency memory, the next state also reads the destination base right after that edge. The bench provokes this with a stack-pop source combined with a stack-indexed destination, and with an immediate source combined with a PC-relative destination. It judges the result by the reported destination address and the final SP and PC values. Every vector also runs with memory latencies of 0 to 3 cycles. The total cycle count and the number of request cycles must match one cycle plus one wait per memory state.

// File: rtl/opnd_pkg.sv
`timescale 1ns/1ps
package opnd_pkg;
  localparam int IW  = 16;
  localparam int RIW = 4;

  localparam logic [RIW-1:0] REG_PC = 4'd0;
  localparam logic [RIW-1:0] REG_SP = 4'd1;
  localparam logic [RIW-1:0] REG_SR = 4'd2;
  localparam logic [RIW-1:0] REG_CG = 4'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEXT,
    ST_SRD,
    ST_DEXT,
    ST_DONE
  } seq_st_e;

  typedef enum logic [1:0] {
    DK_REG  = 2'd0,
    DK_MEM  = 2'd1,
    DK_DROP = 2'd2
  } dst_kind_e;

  // Field order follows the bit layout of the instruction word, MSB first.
  typedef struct packed {
    logic [3:0]     op;
    logic [RIW-1:0] sreg;
    logic           dmode;
    logic           bw;
    logic [1:0]     smode;
    logic [RIW-1:0] dreg;
  } ins_f_t;
endpackage

// File: rtl/opnd_constgen.sv
`timescale 1ns/1ps
module opnd_constgen
  import opnd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [RIW-1:0] sreg,
  input  logic [1:0]     smode,
  output logic           hit,
  output logic [DW-1:0]  val
);
  always_comb begin
    hit = 1'b0;
    val = '0;
    if (sreg == REG_CG) begin
      hit = 1'b1;
      unique case (smode)
        2'b00:   val = '0;
        2'b01:   val = DW'(1);
        2'b10:   val = DW'(2);
        default: val = '1;
      endcase
    end else if (sreg == REG_SR && smode[1]) begin
      hit = 1'b1;
      val = smode[0] ? DW'(8) : DW'(4);
    end
  end
endmodule

// File: rtl/opnd_decode.sv
`timescale 1ns/1ps
module opnd_decode
  import opnd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [IW-1:0] word,
  output ins_f_t        fld,
  output logic          need_sext,
  output logic          need_srd,
  output logic          need_dext,
  output logic          is_const,
  output logic [DW-1:0] cval
);
  opnd_constgen #(.DW(DW)) u_cg (
    .sreg  (fld.sreg),
    .smode (fld.smode),
    .hit   (is_const),
    .val   (cval)
  );

  always_comb begin
    fld       = ins_f_t'(word);
    need_sext = (fld.smode == 2'b01) && (fld.sreg != REG_CG);
    need_srd  = need_sext || (fld.smode[1] && !is_const);
    need_dext = fld.dmode && (fld.dreg != REG_CG);
  end
endmodule

// File: rtl/opnd_ea_add.sv
`timescale 1ns/1ps
module opnd_ea_add
  import opnd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [RIW-1:0] ridx,
  input  logic [DW-1:0]  pc,
  input  logic [DW-1:0]  rval,
  input  logic [DW-1:0]  idx,
  output logic [DW-1:0]  addr
);
  logic [DW-1:0] base;

  always_comb begin
    if (ridx == REG_SR)      base = '0;
    else if (ridx == REG_PC) base = pc;
    else                     base = rval;
    addr = base + idx;
  end
endmodule

// File: rtl/opnd_seq.sv
`timescale 1ns/1ps
module opnd_seq
  import opnd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_valid,
  output logic                instr_ready,
  input  logic [15:0]         instr_word,
  output logic                mem_req,
  output logic [DW-1:0]       mem_addr,
  input  logic                mem_rvalid,
  input  logic [DW-1:0]       mem_rdata,
  output logic [3:0]          rf_rs_addr,
  input  logic [DW-1:0]       rf_rs_data,
  output logic [3:0]          rf_rd_addr,
  input  logic [DW-1:0]       rf_rd_data,
  output logic                rf_we,
  output logic [3:0]          rf_waddr,
  output logic [DW-1:0]       rf_wdata,
  output logic                done,
  output logic [DW-1:0]       src_val,
  output logic [1:0]          dst_kind,
  output logic [DW-1:0]       dst_loc,
  output logic [3:0]          op_out,
  output logic                byte_out
);
  localparam logic [DW-1:0] PC_STEP = DW'(2);
  localparam logic [DW-1:0] B_STEP  = DW'(1);

  seq_st_e       st_q, st_d;
  ins_f_t        dec_f, f_q;
  logic          dec_sext, dec_srd, dec_dext, dec_const;
  logic [DW-1:0] dec_cval;
  logic          dx_q;
  logic [DW-1:0] pc_q, ea_q, sval_q, dloc_q;
  dst_kind_e     dk_q;
  logic          accept, mem_done;
  logic [DW-1:0] sbase, src_ea, dst_ea, inc_step;

  opnd_decode #(.DW(DW)) u_dec (
    .word      (instr_word),
    .fld       (dec_f),
    .need_sext (dec_sext),
    .need_srd  (dec_srd),
    .need_dext (dec_dext),
    .is_const  (dec_const),
    .cval      (dec_cval)
  );

  opnd_ea_add #(.DW(DW)) u_src_ea (
    .ridx (f_q.sreg),
    .pc   (pc_q),
    .rval (rf_rs_data),
    .idx  (mem_rdata),
    .addr (src_ea)
  );

  opnd_ea_add #(.DW(DW)) u_dst_ea (
    .ridx (f_q.dreg),
    .pc   (pc_q),
    .rval (rf_rd_data),
    .idx  (mem_rdata),
    .addr (dst_ea)
  );

  // Handshakes and register-file port steering
  always_comb begin
    instr_ready = (st_q == ST_IDLE);
    accept      = instr_valid && instr_ready;
    mem_req     = (st_q == ST_SEXT) || (st_q == ST_SRD) || (st_q == ST_DEXT);
    mem_done    = mem_req && mem_rvalid;
    mem_addr    = (st_q == ST_SRD) ? ea_q : pc_q;
    rf_rs_addr  = (st_q == ST_IDLE) ? dec_f.sreg : f_q.sreg;
    rf_rd_addr  = (st_q == ST_IDLE) ? REG_PC : f_q.dreg;
    sbase       = (dec_f.sreg == REG_PC) ? rf_rd_data : rf_rs_data;
    inc_step    = (f_q.bw && f_q.sreg != REG_PC && f_q.sreg != REG_SP) ? B_STEP : PC_STEP;
    rf_we       = mem_done && ((st_q != ST_SRD) || (f_q.smode == 2'b11));
    rf_waddr    = (st_q == ST_SRD) ? f_q.sreg : REG_PC;
    rf_wdata    = (st_q == ST_SRD) ? (ea_q + inc_step) : (pc_q + PC_STEP);
  end

  // Next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        if (dec_sext)      st_d = ST_SEXT;
        else if (dec_srd)  st_d = ST_SRD;
        else if (dec_dext) st_d = ST_DEXT;
        else               st_d = ST_DONE;
      end
      ST_SEXT: if (mem_rvalid) st_d = ST_SRD;
      ST_SRD:  if (mem_rvalid) st_d = dx_q ? ST_DEXT : ST_DONE;
      ST_DEXT: if (mem_rvalid) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      f_q    <= '0;
      dx_q   <= 1'b0;
      pc_q   <= '0;
      ea_q   <= '0;
      sval_q <= '0;
      dloc_q <= '0;
      dk_q   <= DK_REG;
    end else begin
      st_q <= st_d;
      if (accept) begin
        f_q    <= dec_f;
        dx_q   <= dec_dext;
        pc_q   <= rf_rd_data;
        ea_q   <= sbase;
        sval_q <= dec_const ? dec_cval : sbase;
        if (dec_f.dreg == REG_CG) begin
          dk_q   <= DK_DROP;
          dloc_q <= '0;
        end else if (!dec_f.dmode) begin
          dk_q   <= DK_REG;
          dloc_q <= DW'(dec_f.dreg);
        end else begin
          dk_q   <= DK_MEM;
          dloc_q <= '0;
        end
      end
      if (mem_done) begin
        unique case (st_q)
          ST_SEXT: begin
            ea_q <= src_ea;
            pc_q <= pc_q + PC_STEP;
          end
          ST_SRD: begin
            sval_q <= mem_rdata;
            if (f_q.smode == 2'b11 && f_q.sreg == REG_PC) pc_q <= pc_q + PC_STEP;
          end
          ST_DEXT: begin
            dloc_q <= dst_ea;
            pc_q   <= pc_q + PC_STEP;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    done     = (st_q == ST_DONE);
    src_val  = sval_q;
    dst_kind = dk_q;
    dst_loc  = dloc_q;
    op_out   = f_q.op;
    byte_out = f_q.bw;
  end
endmodule

// File: rtl/opnd_seq_chk.sv
`timescale 1ns/1ps
module opnd_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_valid,
  input logic          instr_ready,
  input logic [15:0]   instr_word,
  input logic          mem_req,
  input logic [DW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          rf_we,
  input logic          done
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ready |-> (!mem_req && !rf_we && !done)); // R1

  AST_WRITE_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_req && mem_rvalid)); // R6

  AST_CONST_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && instr_word[11:8] == 4'd3 &&
     (!instr_word[7] || instr_word[3:0] == 4'd3)) |=> (done && !mem_req)); // R3

  AST_DROP_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && instr_word[3:0] == 4'd3 &&
     !instr_word[5] && instr_word[11:8] != 4'd2 &&
     !(instr_word[5:4] == 2'b01 && instr_word[11:8] != 4'd3)) |=> done); // R7
endmodule

bind opnd_seq opnd_seq_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_ready (instr_ready),
  .instr_word  (instr_word),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_rvalid  (mem_rvalid),
  .rf_we       (rf_we),
  .done        (done)
);

// File: tb/sim_opnd_seq.sv
`timescale 1ns/1ps
module sim_opnd_seq;
  localparam int DW = 16;
  localparam int NV = 24;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, instr_valid, instr_ready;
  logic [15:0]   instr_word;
  logic          mem_req, mem_rvalid;
  logic [DW-1:0] mem_addr, mem_rdata;
  logic [3:0]    rf_rs_addr, rf_rd_addr, rf_waddr;
  logic [DW-1:0] rf_rs_data, rf_rd_data, rf_wdata;
  logic          rf_we, done, byte_out;
  logic [DW-1:0] src_val, dst_loc;
  logic [1:0]    dst_kind;
  logic [3:0]    op_out;

  logic [15:0] regs [16];
  logic [15:0] mem  [64];
  int          lat = 0;
  logic [3:0]  wcnt = '0;
  int          errs = 0, checks = 0;
  bit          finished = 0;

  opnd_seq #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rf_rs_addr(rf_rs_addr),
    .rf_rs_data(rf_rs_data), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .done(done),
    .src_val(src_val), .dst_kind(dst_kind), .dst_loc(dst_loc), .op_out(op_out),
    .byte_out(byte_out)
  );

  assign rf_rs_data = regs[rf_rs_addr];
  assign rf_rd_data = regs[rf_rd_addr];
  assign mem_rvalid = mem_req && (wcnt == lat[3:0]);
  assign mem_rdata  = mem[mem_addr[6:1]];

  always @(posedge clk) begin
    if (rf_we) regs[rf_waddr] <= rf_wdata;
    if (mem_req && !mem_rvalid) wcnt <= wcnt + 4'd1;
    else wcnt <= '0;
  end

  typedef struct packed {
    logic [15:0] ins;
    logic [15:0] e1;
    logic [15:0] e2;
    logic [15:0] src;
    logic [1:0]  kind;
    logic [15:0] loc;
    logic [15:0] pc;
    logic [3:0]  ridx;
    logic [15:0] rval;
    logic [1:0]  nmem;
  } vec_t;

  // Register start values: R0=0010 R1=0040 R2=0105 R3=7777 Rn=0020+2*(n-4)
  // Memory word at byte address a: 5A00 + a[6:1], except 0010 -> e1, 0012 -> e2
  localparam vec_t VEC [NV] = '{
    '{16'h4405, 16'h0000, 16'h0000, 16'h0020, 2'd0, 16'h0005, 16'h0010, 4'd4, 16'h0020, 2'd0},
    '{16'h4204, 16'h0000, 16'h0000, 16'h0105, 2'd0, 16'h0004, 16'h0010, 4'd2, 16'h0105, 2'd0},
    '{16'h4334, 16'h0000, 16'h0000, 16'hFFFF, 2'd0, 16'h0004, 16'h0010, 4'd3, 16'h7777, 2'd0},
    '{16'h4314, 16'h0000, 16'h0000, 16'h0001, 2'd0, 16'h0004, 16'h0010, 4'd3, 16'h7777, 2'd0},
    '{16'h4224, 16'h0000, 16'h0000, 16'h0004, 2'd0, 16'h0004, 16'h0010, 4'd2, 16'h0105, 2'd0},
    '{16'h4234, 16'h0000, 16'h0000, 16'h0008, 2'd0, 16'h0004, 16'h0010, 4'd2, 16'h0105, 2'd0},
    '{16'h4324, 16'h0000, 16'h0000, 16'h0002, 2'd0, 16'h0004, 16'h0010, 4'd3, 16'h7777, 2'd0},
    '{16'h4304, 16'h0000, 16'h0000, 16'h0000, 2'd0, 16'h0004, 16'h0010, 4'd3, 16'h7777, 2'd0},
    '{16'h4415, 16'h0006, 16'h0000, 16'h5A13, 2'd0, 16'h0005, 16'h0012, 4'd4, 16'h0020, 2'd2},
    '{16'h4215, 16'h0030, 16'h0000, 16'h5A18, 2'd0, 16'h0005, 16'h0012, 4'd2, 16'h0105, 2'd2},
    '{16'h4015, 16'h0020, 16'h0000, 16'h5A18, 2'd0, 16'h0005, 16'h0012, 4'd0, 16'h0012, 2'd2},
    '{16'h4625, 16'h0000, 16'h0000, 16'h5A12, 2'd0, 16'h0005, 16'h0010, 4'd6, 16'h0024, 2'd1},
    '{16'h4635, 16'h0000, 16'h0000, 16'h5A12, 2'd0, 16'h0005, 16'h0010, 4'd6, 16'h0026, 2'd1},
    '{16'h4675, 16'h0000, 16'h0000, 16'h5A12, 2'd0, 16'h0005, 16'h0010, 4'd6, 16'h0025, 2'd1},
    '{16'h4175, 16'h0000, 16'h0000, 16'h5A20, 2'd0, 16'h0005, 16'h0010, 4'd1, 16'h0042, 2'd1},
    '{16'h4035, 16'h1234, 16'h0000, 16'h1234, 2'd0, 16'h0005, 16'h0012, 4'd0, 16'h0012, 2'd1},
    '{16'h4487, 16'h0010, 16'h0000, 16'h0020, 2'd1, 16'h0036, 16'h0012, 4'd7, 16'h0026, 2'd1},
    '{16'h4482, 16'h0100, 16'h0000, 16'h0020, 2'd1, 16'h0100, 16'h0012, 4'd2, 16'h0105, 2'd1},
    '{16'h4483, 16'h0000, 16'h0000, 16'h0020, 2'd2, 16'h0000, 16'h0010, 4'd3, 16'h7777, 2'd0},
    '{16'h4495, 16'h0006, 16'h0004, 16'h5A13, 2'd1, 16'h0026, 16'h0014, 4'd5, 16'h0022, 2'd3},
    '{16'h41B1, 16'h0002, 16'h0000, 16'h5A20, 2'd1, 16'h0044, 16'h0012, 4'd1, 16'h0042, 2'd2},
    '{16'h40B0, 16'h1234, 16'h0008, 16'h1234, 2'd1, 16'h001A, 16'h0014, 4'd0, 16'h0014, 2'd2},
    '{16'h4333, 16'h0000, 16'h0000, 16'hFFFF, 2'd2, 16'h0000, 16'h0010, 4'd3, 16'h7777, 2'd0},
    '{16'h4133, 16'h0000, 16'h0000, 16'h5A20, 2'd2, 16'h0000, 16'h0010, 4'd1, 16'h0042, 2'd1}
  };

  function automatic string tag_of(input int i);
    if (i < 2)       return "R2";
    else if (i < 8)  return "R3";
    else if (i < 11) return "R4";
    else if (i < 12) return "R5";
    else if (i < 16) return "R6";
    else if (i < 19) return "R7";
    else if (i < 22) return "R8";
    else             return "R7";
  endfunction

  task automatic chk(input logic ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic prep(input logic [15:0] e1, input logic [15:0] e2);
    regs[0] = 16'h0010; regs[1] = 16'h0040; regs[2] = 16'h0105; regs[3] = 16'h7777;
    for (int r = 4; r < 16; r++) regs[r] = 16'h0020 + 16'(2 * (r - 4));
    mem[8] = e1;
    mem[9] = e2;
  endtask

  task automatic run_vec(input int i, input int l);
    vec_t v;
    int cyc, reqc, expc;
    bit got, prev_wait, busy_ready;
    logic [DW-1:0] prev_addr;
    string t;
    v = VEC[i];
    t = tag_of(i);
    prep(v.e1, v.e2);
    lat = l;
    instr_word = v.ins;
    instr_valid = 1'b1;
    cyc = 0; reqc = 0; got = 0; prev_wait = 0; busy_ready = 0; prev_addr = '0;
    while (!got && cyc < 60) begin
      @(negedge clk);
      if (cyc == 0) instr_valid = 1'b0;
      cyc++;
      if (prev_wait) chk(mem_req && mem_addr == prev_addr, "R9", "address held while waiting",
                         {15'd0, mem_req, mem_addr}, {15'd0, 1'b1, prev_addr});
      if (mem_req) reqc++;
      if (instr_ready) busy_ready = 1;
      prev_wait = mem_req && !mem_rvalid;
      prev_addr = mem_addr;
      got = done;
    end
    expc = int'(v.nmem) * (l + 1);
    chk(got, "R10", "done seen", 32'(got), 32'd1);
    chk(!busy_ready, "R1", "ready low while busy", 32'(busy_ready), 32'd0);
    chk(cyc == 1 + expc, "R9", "cycles to done", 32'(cyc), 32'(1 + expc));
    chk(reqc == expc, "R9", "request cycles", 32'(reqc), 32'(expc));
    chk(src_val == v.src, t, "source value", 32'(src_val), 32'(v.src));
    chk(dst_kind == v.kind, t, "destination kind", 32'(dst_kind), 32'(v.kind));
    chk(dst_loc == v.loc, t, "destination location", 32'(dst_loc), 32'(v.loc));
    chk(regs[0] == v.pc, t, "program counter", 32'(regs[0]), 32'(v.pc));
    chk(regs[v.ridx] == v.rval, t, "register after", 32'(regs[v.ridx]), 32'(v.rval));
    chk(op_out == v.ins[15:12] && byte_out == v.ins[6], "R1", "opcode and byte flag",
        {27'd0, byte_out, op_out}, {27'd0, v.ins[6], v.ins[15:12]});
    @(negedge clk);
    chk(!done, "R10", "done single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    #750000;
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 16'h5A00 + 16'(k);
    prep(16'h0, 16'h0);
    rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(instr_ready, "R1", "ready after reset", 32'(instr_ready), 32'd1);
    chk(!done, "R10", "done low after reset", 32'(done), 32'd0);
    chk(!mem_req, "R9", "no request after reset", 32'(mem_req), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(i, i % 4);

    repeat (3) @(negedge clk);
    chk(src_val == 16'h5A20 && dst_kind == 2'd2, "R10", "outputs held while idle",
        {14'd0, dst_kind, src_val}, {14'd0, 2'd2, 16'h5A20});

    // Reset in the middle of a stalled extension fetch
    prep(16'h0006, 16'h0);
    lat = 6;
    instr_word = 16'h4415;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    @(negedge clk);
    chk(mem_req && !instr_ready, "R9", "stalled in fetch", {30'd0, mem_req, instr_ready}, 32'd2);
    rst_n = 1'b0;
    #1;
    chk(instr_ready && !mem_req && !done, "R1", "reset mid-sequence",
        {29'd0, instr_ready, mem_req, done}, 32'd4);
    @(negedge clk);
    rst_n = 1'b1;
    chk(regs[0] == 16'h0010, "R4", "PC untouched by aborted fetch", 32'(regs[0]), 32'h10);
    run_vec(20, 0);
    run_vec(21, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule